// File: doc/BRIEF.md
# Rollover Character Video Timing Chain

This block produces every timing signal a text-mode display needs from one pixel clock. A pixel counter divides the clock into character cells. A column counter counts cells and simply overflows at its natural power of two. No comparator resets it at the end of a line. Horizontal sync and the side margins sit at column values that still address real memory cells, and the display never shows those cells. The video RAM address is just the row number placed above the column number. As a result the character memory has holes in it, and no adder or terminal-count logic is needed.

Each text row is a parameterised number of scanlines tall. A scanline counter inside the row drives the row counter. After the last text row, a run of blank lines stretches the frame to the wanted field length, and vertical sync falls inside that run. The address, load strobe, blank and both syncs are registered with equal latency, so every output describes the same character cell in the same cycle. A character ROM and a shift register, both outside this block, turn the address and strobe into pixels.

Top module: `charvid_timing`

## Requirements
- R1: While `rst_n` is low, `vram_addr` is 0, `char_load` is 0, `blank` is 1, and `hsync` and `vsync` are 0.
- R2: `char_load` is high for exactly one pixel clock in every 2^PIX_BITS. That pixel is the last pixel of its character cell, and in it `vram_addr` still holds that cell's address.
- R3: The column field `vram_addr[COL_BITS-1:0]` advances by one per character cell. It goes from all ones back to 0 by overflow alone, so one line is 2^COL_BITS cells.
- R4: The row field `vram_addr[COL_BITS+ROW_BITS-1:COL_BITS]` holds text line / SCAN_PER_ROW during the 2^ROW_BITS text rows and holds 0 during the trailing blank lines.
- R5: `blank` is 0 only when the column lies in [VIS_START, VIS_START+VIS_COLS) and the line belongs to a text row. It is 1 at all other times.
- R6: `hsync` is 1 exactly when the column lies in [HS_START, HS_START+HS_LEN). This range lies wholly inside the blanked columns.
- R7: A frame is 2^ROW_BITS*SCAN_PER_ROW text lines followed by TAIL_LINES blank lines. The next frame then starts at row 0, column 0.
- R8: `vsync` is 1 exactly on tail lines whose index inside the tail lies in [VS_START, VS_START+VS_LEN), for every column of those lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| vram_addr | output | COL_BITS+ROW_BITS | Character memory address, row field above column field |
| char_load | output | 1 | One-pixel strobe that loads the next glyph into the pixel shifter |
| blank | output | 1 | High outside the visible text area |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench targets the column overflow from all ones to zero. A design with a stray compare-and-reset there would produce short lines and shift every later address. It also checks that the row field returns to zero across the blank tail and that the frame wraps back to row 0. A wrong tail length or a row counter that keeps counting would show up as vsync on the wrong lines. Window edges are compared on every pixel of two whole frames, so an off-by-one bound on blank, hsync or vsync gives a miscompare at the exact column or line. The load strobe is compared against the address in the same cycle, which catches any latency mismatch between the two.

// File: rtl/charvid_pkg.sv
package charvid_pkg;
  // Half-open window test used by all window decoders.
  function automatic logic in_win(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction
endpackage

// File: rtl/charvid_rst_sync.sv
module charvid_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/charvid_hcount.sv
module charvid_hcount #(
  parameter int PIX_BITS = 3,
  parameter int COL_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [PIX_BITS-1:0] pix,
  output logic [COL_BITS-1:0] col,
  output logic                cell_end,
  output logic                line_end
);
  logic [PIX_BITS-1:0] pix_nxt;
  logic [COL_BITS-1:0] col_nxt;
  logic                col_en;

  always_comb begin
    cell_end = &pix;
    line_end = cell_end & (&col);
    col_en   = cell_end;
    pix_nxt  = pix + 1'b1;
    col_nxt  = col + 1'b1;   // natural overflow, no terminal compare
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix <= '0;
      col <= '0;
    end else begin
      pix <= pix_nxt;
      if (col_en) col <= col_nxt;
    end
  end

  // R3: all-ones column rolls to zero at the cell boundary
  a_r3_col_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (col == '0));
  // R3: column holds inside a cell
  a_r3_col_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_end |=> $stable(col));
endmodule

// File: rtl/charvid_vcount.sv
module charvid_vcount #(
  parameter int ROW_BITS     = 4,
  parameter int SCAN_PER_ROW = 12,
  parameter int TAIL_LINES   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_adv,
  output logic [ROW_BITS-1:0] row,
  output logic                in_tail,
  output logic [31:0]         tail_idx
);
  localparam int SCAN_W = (SCAN_PER_ROW > 1) ? $clog2(SCAN_PER_ROW) : 1;
  localparam int TAIL_W = (TAIL_LINES > 1) ? $clog2(TAIL_LINES) : 1;
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCAN_PER_ROW - 1);
  localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(TAIL_LINES - 1);

  logic [SCAN_W-1:0]   scan, scan_nxt;
  logic [TAIL_W-1:0]   tcnt, tcnt_nxt;
  logic [ROW_BITS-1:0] row_nxt;
  logic                tail_nxt;

  always_comb begin
    scan_nxt = scan;
    row_nxt  = row;
    tcnt_nxt = tcnt;
    tail_nxt = in_tail;
    if (!in_tail) begin
      if (scan == SCAN_LAST) begin
        scan_nxt = '0;
        row_nxt  = row + 1'b1;
        if (&row) tail_nxt = (TAIL_LINES > 0);
      end else begin
        scan_nxt = scan + 1'b1;
      end
    end else begin
      if (tcnt == TAIL_LAST) begin
        tcnt_nxt = '0;
        tail_nxt = 1'b0;
      end else begin
        tcnt_nxt = tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan    <= '0;
      row     <= '0;
      tcnt    <= '0;
      in_tail <= 1'b0;
    end else if (line_adv) begin
      scan    <= scan_nxt;
      row     <= row_nxt;
      tcnt    <= tcnt_nxt;
      in_tail <= tail_nxt;
    end
  end

  always_comb tail_idx = 32'(tcnt);

  // R4: row field stays zero through the blank tail
  a_r4_row_zero_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    in_tail |-> (row == '0));
  // R7: tail always ends back in the first text row
  a_r7_tail_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_tail) |-> (row == '0) && (scan == '0));
endmodule

// File: rtl/charvid_timing.sv
module charvid_timing #(
  parameter int PIX_BITS     = 3,
  parameter int COL_BITS     = 6,
  parameter int ROW_BITS     = 4,
  parameter int SCAN_PER_ROW = 12,
  parameter int TAIL_LINES   = 20,
  parameter int VIS_START    = 16,
  parameter int VIS_COLS     = 48,
  parameter int HS_START     = 2,
  parameter int HS_LEN       = 6,
  parameter int VS_START     = 4,
  parameter int VS_LEN       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [COL_BITS+ROW_BITS-1:0] vram_addr,
  output logic                         char_load,
  output logic                         blank,
  output logic                         hsync,
  output logic                         vsync
);
  import charvid_pkg::*;

  localparam int ADDR_W = COL_BITS + ROW_BITS;

  logic                srst_n;
  logic [PIX_BITS-1:0] pix;
  logic [COL_BITS-1:0] col;
  logic                cell_end, line_end;
  logic [ROW_BITS-1:0] row;
  logic                in_tail;
  logic [31:0]         tail_idx;

  logic [ADDR_W-1:0]   addr_d;
  logic                load_d, blank_d, hs_d, vs_d;

  charvid_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  charvid_hcount #(.PIX_BITS(PIX_BITS), .COL_BITS(COL_BITS)) u_h (
    .clk(clk), .rst_n(srst_n), .pix(pix), .col(col),
    .cell_end(cell_end), .line_end(line_end)
  );

  charvid_vcount #(.ROW_BITS(ROW_BITS), .SCAN_PER_ROW(SCAN_PER_ROW),
                   .TAIL_LINES(TAIL_LINES)) u_v (
    .clk(clk), .rst_n(srst_n), .line_adv(line_end),
    .row(row), .in_tail(in_tail), .tail_idx(tail_idx)
  );

  always_comb begin
    addr_d  = {row, col};
    load_d  = cell_end;
    blank_d = in_tail || !in_win(int'(col), VIS_START, VIS_COLS);
    hs_d    = in_win(int'(col), HS_START, HS_LEN);
    vs_d    = in_tail && in_win(int'(tail_idx), VS_START, VS_LEN);
  end

  // One register stage for every output keeps them aligned to one cell.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vram_addr <= '0;
      char_load <= 1'b0;
      blank     <= 1'b1;
      hsync     <= 1'b0;
      vsync     <= 1'b0;
    end else begin
      vram_addr <= addr_d;
      char_load <= load_d;
      blank     <= blank_d;
      hsync     <= hs_d;
      vsync     <= vs_d;
    end
  end

  // R2: strobe lasts one pixel
  a_r2_load_single: assert property (@(posedge clk) disable iff (!srst_n)
    char_load |=> !char_load);
  // R3: column field moves by one right after each strobe
  a_r3_col_step: assert property (@(posedge clk) disable iff (!srst_n)
    char_load |=> (vram_addr[COL_BITS-1:0] ==
                   COL_BITS'($past(vram_addr[COL_BITS-1:0]) + 1'b1)));
  // R6: sync stays inside blanked columns
  a_r6_hsync_blanked: assert property (@(posedge clk) disable iff (!srst_n)
    hsync |-> blank);
  // R8: vertical sync only during blanking
  a_r8_vsync_blanked: assert property (@(posedge clk) disable iff (!srst_n)
    vsync |-> blank);
endmodule

// File: tb/charvid_timing_bench.sv
module charvid_timing_bench;
  localparam int PB = 3, CB = 6, RB = 4, SPR = 2, TL = 6;
  localparam int VSS = 16, VSC = 48, HSS = 2, HSL = 6, VSY = 2, VSL = 2;
  localparam int PPC   = 1 << PB;
  localparam int COLS  = 1 << CB;
  localparam int TEXTL = (1 << RB) * SPR;
  localparam int LINES = TEXTL + TL;
  localparam int FRAME = LINES * COLS * PPC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CB+RB-1:0] vram_addr;
  logic char_load, blank, hsync, vsync;
  int vectors = 0, fails = 0;

  always #4 clk = ~clk;

  charvid_timing #(.PIX_BITS(PB), .COL_BITS(CB), .ROW_BITS(RB),
    .SCAN_PER_ROW(SPR), .TAIL_LINES(TL), .VIS_START(VSS), .VIS_COLS(VSC),
    .HS_START(HSS), .HS_LEN(HSL), .VS_START(VSY), .VS_LEN(VSL))
  u_charvid_timing (.clk(clk), .rst_n(rst_n), .vram_addr(vram_addr),
    .char_load(char_load), .blank(blank), .hsync(hsync), .vsync(vsync));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (2 * FRAME + 400) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int wait_n;
    // R1: reset values
    repeat (5) @(negedge clk);
    chk("R1 addr", int'(vram_addr), 0);
    chk("R1 load", int'(char_load), 0);
    chk("R1 blank", int'(blank), 1);
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    rst_n = 1'b1;
    wait_n = 0;
    @(negedge clk);
    while (char_load !== 1'b1 && wait_n < 40) begin
      wait_n++;
      @(negedge clk);
    end
    // R2: first strobe comes within a few cycles of release
    chk("R2 first load delay ok", int'(wait_n < 16), 1);
    // Align: this sample is pixel 7 of column 0, line 0.
    for (int n = PPC - 1; n < PPC - 1 + 2 * FRAME; n++) begin
      int px, col, line, row, tix;
      bit text;
      px   = n % PPC;
      col  = (n / PPC) % COLS;
      line = (n / (PPC * COLS)) % LINES;   // R7 frame length
      text = line < TEXTL;
      row  = text ? line / SPR : 0;        // R4
      tix  = line - TEXTL;
      chk("R3/R4 addr", int'(vram_addr), row * COLS + col);
      chk("R2 load", int'(char_load), int'(px == PPC - 1));
      chk("R5 blank", int'(blank), int'(!(text && col >= VSS && col < VSS + VSC)));
      chk("R6 hsync", int'(hsync), int'(col >= HSS && col < HSS + HSL));
      chk("R8 vsync", int'(vsync), int'(!text && tix >= VSY && tix < VSY + VSL));
      @(negedge clk);
    end
    // R1: reasserting reset returns outputs to idle
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 addr again", int'(vram_addr), 0);
    chk("R1 blank again", int'(blank), 1);
    finish_run();
  end
endmodule